// File: doc/BRIEF.md
# Nibble-Configurable Eight-Channel I/O Port Controller

This block is a register bank on a simple microprocessor bus. It controls eight digital I/O channels that form two nibbles of four. Software sets each nibble as a whole to input or to output. In an output nibble every channel gets an on/off drive signal. That signal follows one of three sources: a static data bit, a blink wave made from a slow pulse clock, or a shared PWM input.

A disable input that works without the processor turns every driver off at once. The reset input clears every register, and that also turns all drivers off. The level actually present on each channel pin can be read back at any time. This holds for channels configured as outputs too, so software can compare what it commanded with what the pin shows.

The bus uses an asynchronous-strobe style and is sampled by the block's own clock. A write is captured when the write strobe rises while chip select is low. A read produces data and a pad output enable for as long as chip select and the read strobe are both low.

Top module: `nio_port_ctrl`

## Requirements
- R1: While `rst_n` is low, every register is cleared and `drv` is 0. After reset, every register reads back as 0x00.
- R2: A write takes effect only on a low-to-high transition of `wr_n` while `cs_n` is low. It uses the address and data that were present before the transition. A strobe with `cs_n` high changes nothing.
- R3: `bus_doe` is 1 exactly while `cs_n` and `rd_n` are both low. While `bus_doe` is 1, `bus_dout` carries the addressed register. Address 0x00 is config, 0x01 is output data, 0x02 is blink enable, 0x03 is PWM select and 0x04 is pin level.
- R4: Config bit 0 makes channels 0–3 outputs and config bit 1 makes channels 4–7 outputs. A nibble whose bit is 0 is an input and its `drv` bits are 0.
- R5: For an output channel with no PWM select and no blink enable, `drv[i]` equals bit i of the output data register.
- R6: For a blinking channel, the drive is a 50% square wave. Its period is 2^(S+1) rising edges of `pls_clk`, where S is config bits 4:2. Edges are counted from reset, and the level is bit S of that count. All blinking channels are in phase.
- R7: A channel with its PWM select bit set follows `pwm_in`. PWM select wins over blink enable, and blink enable wins over the data bit.
- R8: While `dis` is 1, `drv` is 0 whatever the registers hold.
- R9: Address 0x04 reads `pin_lvl` for all eight channels, whatever the direction of each nibble. Writes to 0x04 are ignored.
- R10: Addresses 0x05–0x1F read as 0x00 and writes to them are ignored. Config bits 7:5 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus and pulse clock |
| rst_n | input | 1 | Active-low reset, including undervoltage reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; rising edge captures |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 5 | Register address |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Read data toward the bus pad |
| bus_doe | output | 1 | Pad output enable; pad is high-impedance when 0 |
| pls_clk | input | 1 | Slow pulse clock that times blinking |
| pwm_in | input | 1 | Shared PWM source |
| dis | input | 1 | Common disable; forces every driver off |
| pin_lvl | input | 8 | Actual level on each channel pin |
| drv | output | 8 | On/off control for each channel's output stage |

## Verification
The hardest state to reach is the blink phase at the larger divider settings. The drive level there depends on how many pulse-clock edges have passed since reset, and the bench can see that count only through `drv`. The stimulus issues pulse-clock edges one at a time with generous spacing and keeps its own count from reset. It then steps the divider through every setting and compares the blink level after each group of edges. Random configurations mix blink, PWM and static channels under random disable, so the priority order is also exercised while the counter is at arbitrary values.

// File: rtl/nio_pkg.sv
package nio_pkg;
  localparam int NIO_AW  = 5;
  localparam int NIO_DW  = 8;
  localparam int NIO_NCH = 8;
  localparam int NIO_NIB = 4;

  localparam logic [NIO_AW-1:0] A_CFG   = 5'h00;
  localparam logic [NIO_AW-1:0] A_DATA  = 5'h01;
  localparam logic [NIO_AW-1:0] A_BLINK = 5'h02;
  localparam logic [NIO_AW-1:0] A_PWM   = 5'h03;
  localparam logic [NIO_AW-1:0] A_PINS  = 5'h04;

  // Priority: disable, direction, PWM select, blink enable, static bit.
  function automatic logic chan_level(input logic is_out, input logic off,
                                      input logic pwm_sel, input logic pwm,
                                      input logic blk_en, input logic blk,
                                      input logic dat);
    if (off || !is_out) return 1'b0;
    if (pwm_sel)        return pwm;
    if (blk_en)         return blk;
    return dat;
  endfunction

  // Blink level: bit `sel` of the pulse-edge count.
  function automatic logic blink_bit(input logic [7:0] edges, input logic [2:0] sel);
    return edges[sel];
  endfunction
endpackage

// File: rtl/nio_bus_if.sv
module nio_bus_if #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_oe
);
  logic cs_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      wr_q    <= 1'b1;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      cs_q    <= cs_n;
      wr_q    <= wr_n;
      wr_addr <= addr;
      wr_data <= din;
    end
  end

  assign wr_evt = !cs_q && !wr_q && wr_n;
  assign rd_oe  = !cs_n && !rd_n;
endmodule

// File: rtl/nio_regs.sv
module nio_regs
  import nio_pkg::*;
#(
  parameter int AW  = 5,
  parameter int DW  = 8,
  parameter int NCH = 8,
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_evt,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  input  logic           rd_oe,
  input  logic [NCH-1:0] pin_lvl,
  output logic [DW-1:0]  rd_data,
  output logic [NCH/NIB-1:0] nib_out,
  output logic [2:0]     div_sel,
  output logic [NCH-1:0] dat_q,
  output logic [NCH-1:0] blk_q,
  output logic [NCH-1:0] pwm_q
);
  localparam int NNIB  = NCH / NIB;
  localparam int CFG_W = NNIB + 3;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dat_q <= '0;
      blk_q <= '0;
      pwm_q <= '0;
    end else if (wr_evt) begin
      case (wr_addr)
        A_CFG:   cfg_q <= wr_data[CFG_W-1:0];
        A_DATA:  dat_q <= wr_data[NCH-1:0];
        A_BLINK: blk_q <= wr_data[NCH-1:0];
        A_PWM:   pwm_q <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  assign nib_out = cfg_q[NNIB-1:0];
  assign div_sel = cfg_q[CFG_W-1:NNIB];

  always_comb begin
    rd_data = '0;
    if (rd_oe) begin
      case (rd_addr)
        A_CFG:   rd_data = DW'(cfg_q);
        A_DATA:  rd_data = DW'(dat_q);
        A_BLINK: rd_data = DW'(blk_q);
        A_PWM:   rd_data = DW'(pwm_q);
        A_PINS:  rd_data = DW'(pin_lvl);
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/nio_blink.sv
module nio_blink
  import nio_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pls_clk,
  input  logic [2:0] sel,
  output logic       pls_rise,
  output logic       blink
);
  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pls_clk};
      if (pls_rise) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pls_rise = sync_q[1] && !sync_q[2];
  assign blink    = blink_bit(cnt_q[7:0], sel);
endmodule

// File: rtl/nio_port_ctrl.sv
module nio_port_ctrl
  import nio_pkg::*;
#(
  parameter int AW  = NIO_AW,
  parameter int DW  = NIO_DW,
  parameter int NCH = NIO_NCH,
  parameter int NIB = NIO_NIB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           wr_n,
  input  logic           rd_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  bus_din,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe,
  input  logic           pls_clk,
  input  logic           pwm_in,
  input  logic           dis,
  input  logic [NCH-1:0] pin_lvl,
  output logic [NCH-1:0] drv
);
  localparam int NNIB = NCH / NIB;

  logic            wr_evt;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;
  logic            rd_oe;
  logic [NNIB-1:0] nib_out;
  logic [2:0]      div_sel;
  logic [NCH-1:0]  dat_q, blk_q, pwm_q;
  logic            pls_rise, blink;

  nio_bus_if #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .din(bus_din), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_oe(rd_oe)
  );

  nio_regs #(.AW(AW), .DW(DW), .NCH(NCH), .NIB(NIB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(addr), .rd_oe(rd_oe), .pin_lvl(pin_lvl),
    .rd_data(bus_dout), .nib_out(nib_out), .div_sel(div_sel),
    .dat_q(dat_q), .blk_q(blk_q), .pwm_q(pwm_q)
  );

  nio_blink #(.CW(8)) u_blink (
    .clk(clk), .rst_n(rst_n), .pls_clk(pls_clk), .sel(div_sel),
    .pls_rise(pls_rise), .blink(blink)
  );

  assign bus_doe = rd_oe;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign drv[i] = chan_level(nib_out[i/NIB], dis, pwm_q[i], pwm_in,
                               blk_q[i], blink, dat_q[i]);
  end
endmodule

// File: rtl/nio_port_ctrl_chk.sv
module nio_port_ctrl_chk #(
  parameter int NCH = 8,
  parameter int NIB = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           rd_n,
  input logic           bus_doe,
  input logic           dis,
  input logic           pwm_in,
  input logic [NCH-1:0] drv,
  input logic [NCH/NIB-1:0] nib_out,
  input logic [NCH-1:0] pwm_q,
  input logic           wr_evt,
  input logic           pls_rise,
  input logic           blink
);
  assert_reset_off_R1: assert property (@(posedge clk) !rst_n |-> drv == '0);

  assert_doe_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !bus_doe);

  assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> drv == '0);

  assert_blink_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pls_rise && !wr_evt) |=> $stable(blink));

  for (genvar n = 0; n < NCH/NIB; n++) begin : g_nib
    assert_input_nibble_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_out[n] |-> drv[n*NIB +: NIB] == '0);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_pwm
    assert_pwm_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_out[i/NIB] && !dis && pwm_q[i]) |-> drv[i] == pwm_in);
  end
endmodule

bind nio_port_ctrl nio_port_ctrl_chk #(.NCH(NCH), .NIB(NIB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .bus_doe(bus_doe),
  .dis(dis), .pwm_in(pwm_in), .drv(drv), .nib_out(nib_out), .pwm_q(pwm_q),
  .wr_evt(wr_evt), .pls_rise(pls_rise), .blink(blink)
);

// File: tb/nio_port_ctrl_test.sv
`timescale 1ns/1ps
module nio_port_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, wr_n = 1, rd_n = 1;
  logic [4:0] addr = '0;
  logic [7:0] bus_din = '0, bus_dout, pin_lvl = '0, drv;
  logic bus_doe, pls_clk = 0, pwm_in = 0, dis = 0;

  int nvec = 0, nbad = 0;
  bit done = 0;

  logic [7:0] m_cfg = 0, m_dat = 0, m_blk = 0, m_pwm = 0;
  int edges = 0;

  always #2 clk = ~clk;

  nio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .pls_clk(pls_clk), .pwm_in(pwm_in), .dis(dis), .pin_lvl(pin_lvl), .drv(drv)
  );

  function automatic logic [7:0] exp_drv();
    logic [7:0] r;
    logic bl;
    bl = ((edges & 255) >> m_cfg[4:2]) & 1;
    for (int i = 0; i < 8; i++) begin
      if (dis || !m_cfg[i/4]) r[i] = 0;
      else if (m_pwm[i])      r[i] = pwm_in;
      else if (m_blk[i])      r[i] = bl;
      else                    r[i] = m_dat[i];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_cfg & 8'h1F;
      5'h01: return m_dat;
      5'h02: return m_blk;
      5'h03: return m_pwm;
      5'h04: return pin_lvl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    cs_n = !sel; addr = a; bus_din = d; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1;
    repeat (2) @(negedge clk);
    cs_n = 1;
    if (sel) begin
      case (a)
        5'h00: m_cfg = d & 8'h1F;
        5'h01: m_dat = d;
        5'h02: m_blk = d;
        5'h03: m_pwm = d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_rd(input logic [4:0] a, input string req);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #1;
    check("R3 doe", {7'b0, bus_doe}, 8'h01);
    check(req, bus_dout, exp_rd(a));
    rd_n = 1;
    #1;
    check("R3 doe off", {7'b0, bus_doe}, 8'h00);
    cs_n = 1;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); pls_clk = 1;
      repeat (5) @(negedge clk); pls_clk = 0;
      repeat (5) @(negedge clk);
      edges++;
    end
  endtask

  task automatic chk_drv(input string req);
    @(negedge clk); #1;
    check(req, drv, exp_drv());
  endtask

  initial begin
    #800000;
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 drv in reset", drv, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) bus_rd(a[4:0], "R1 reset value");

    // R4/R5: lower nibble out only
    bus_wr(5'h01, 8'hA5, 1);
    bus_wr(5'h00, 8'h01, 1);
    chk_drv("R4 lower out");
    check("R5 lower data", drv, 8'h05);
    bus_wr(5'h00, 8'h03, 1);
    check("R5 all data", drv, 8'hA5);
    // R2: write with cs_n high ignored
    bus_wr(5'h01, 8'h3C, 0);
    chk_drv("R2 cs high ignored");
    bus_rd(5'h01, "R2 readback unchanged");
    // R9/R10
    pin_lvl = 8'h96;
    bus_rd(5'h04, "R9 pin readback");
    bus_wr(5'h04, 8'hFF, 1);
    bus_rd(5'h04, "R9 pin write ignored");
    bus_wr(5'h07, 8'hFF, 1);
    bus_rd(5'h07, "R10 unmapped read");
    bus_wr(5'h00, 8'hE3, 1);
    bus_rd(5'h00, "R10 cfg upper bits zero");
    chk_drv("R10 unmapped write no effect");
    // R8
    dis = 1; chk_drv("R8 disable"); dis = 0;
    // R7 priority over blink
    bus_wr(5'h02, 8'hFF, 1);
    bus_wr(5'h03, 8'h0F, 1);
    pwm_in = 1; chk_drv("R7 pwm high");
    pwm_in = 0; chk_drv("R7 pwm low");
    // R6: every divider setting
    for (int s = 0; s < 8; s++) begin
      bus_wr(5'h00, {3'b0, s[2:0], 2'b11}, 1);
      for (int k = 0; k < 4; k++) begin
        pulse((s < 3) ? 1 : (1 << (s - 1)));
        chk_drv("R6 blink phase");
      end
    end

    // Random mix
    for (int it = 0; it < 150; it++) begin
      logic [4:0] ra;
      bus_wr(5'h00, $urandom & 8'hFF, 1);
      bus_wr(5'h01, $urandom & 8'hFF, 1);
      bus_wr(5'h02, $urandom & 8'hFF, 1);
      bus_wr(5'h03, $urandom & 8'hFF, 1);
      dis = ($urandom % 5) == 0;
      pwm_in = $urandom & 1;
      pin_lvl = $urandom & 8'hFF;
      if ($urandom & 1) pulse($urandom % 3);
      chk_drv("R7 random priority");
      ra = $urandom % 8;
      bus_rd(ra, "R3 random read");
    end
    dis = 0;

    // R1: reset again clears registers
    @(negedge clk); rst_n = 0;
    m_cfg = 0; m_dat = 0; m_blk = 0; m_pwm = 0; edges = 0;
    repeat (2) @(negedge clk);
    check("R1 drv in reset", drv, 8'h00);
    rst_n = 1;
    for (int a = 0; a < 4; a++) bus_rd(a[4:0], "R1 cleared after reset");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule